// File: doc/BRIEF.md
# Bus Access Policy Firewall

This block guards one memory-mapped initiator port. Each request (address, direction, transfer size and write data) is captured into a holding buffer. In parallel, the address goes through a small region table, which names one entry of a policy store. A compare stage then tests the request against that policy. A request that passes is replayed unchanged toward the system side, and the downstream response is handed back. A request that fails never leaves the block: it is answered locally with an error and zero data, and an attack pulse is raised.

A configuration port lets a management agent rewrite region entries and policies, set the violation threshold and lift a quarantine. While the agent raises `cfg_hold`, the block neither accepts new requests nor evaluates a pending one, so no decision is ever made against a policy that is only partly written. Violations are counted. When the count reaches the threshold, the port is quarantined and every later request is refused until software clears it.

Only one transaction is in flight at a time. A request accepted at clock edge E is decided at edge E+2. A refused request shows `rsp_valid` for the single cycle after that edge.

Top module: `fw_access_guard`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `fwd_valid`, `attack_evt` and `quarantined` are 0, the violation threshold is 3, every region matches nothing and every policy permits nothing.
- R2: A region matches when base <= address <= limit, both bounds inclusive. When regions overlap, the lowest-numbered region wins. An address that matches no region is refused.
- R3: A region entry is written with `cfg_kind`=0. `cfg_wdata` bits [AW-1:0] hold the base, bits [2AW-1:AW] the limit and bits [2AW+2:2AW] the policy index. A policy is written with `cfg_kind`=1: bit 0 permits reads, bit 1 permits writes, and bits [9:2] are a mask of allowed size codes. A request is permitted only if the bit for its direction is set and mask bit [`req_size`] is set.
- R4: A permitted request appears once on the forward side with address, size, direction and write data unchanged. `fwd_valid` stays asserted with stable fields until `fwd_ready` is seen. The downstream read data and error flag are then returned to the initiator.
- R5: A refused request is never forwarded. It is answered with `rsp_err`=1 and `rsp_rdata`=0. Any response that carries an error also carries zero data.
- R6: Each refused request that arrives while the port is not quarantined produces exactly one single-cycle `attack_evt` pulse.
- R7: Each such violation increments a saturating counter. When the counter reaches the threshold (written with `cfg_kind`=2 into bits [VW-1:0]), `quarantined` rises in the same cycle as the refusing response.
- R8: While quarantined, every request is refused without an attack pulse and without counting. Quarantine persists until a `cfg_kind`=3 write, which clears both the quarantine and the counter.
- R9: While `cfg_hold` is 1, `req_ready` is 0 and a pending request is not decided. A request decided after the hold is released uses the policy written during the hold.
- R10: `rsp_valid` is a single-cycle pulse, issued once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Initiator request present |
| req_ready | output | 1 | Request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_size | input | 3 | Transfer size code |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response pulse to initiator |
| rsp_rdata | output | DW | Read data returned |
| rsp_err | output | 1 | Error response |
| fwd_valid | output | 1 | Forwarded request present |
| fwd_ready | input | 1 | System side takes the forwarded request |
| fwd_write | output | 1 | Forwarded direction |
| fwd_addr | output | AW | Forwarded address |
| fwd_size | output | 3 | Forwarded size code |
| fwd_wdata | output | DW | Forwarded write data |
| dn_rsp_valid | input | 1 | System-side response present |
| dn_rdata | input | DW | System-side read data |
| dn_err | input | 1 | System-side error |
| cfg_hold | input | 1 | Freeze request handling during a policy update |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 region, 1 policy, 2 threshold, 3 clear quarantine |
| cfg_index | input | IXW | Region or policy number |
| cfg_wdata | input | 2*AW+PIW | Configuration word |
| attack_evt | output | 1 | Violation pulse |
| quarantined | output | 1 | Port is quarantined |

## Verification
The assertions check, on every cycle, the properties that need no knowledge of the policy contents:
- no forward is issued while the port is quarantined;
- nothing is accepted under `cfg_hold`;
- error responses carry zero data;
- the response and attack pulses each last one cycle;
- quarantine holds until it is cleared;
- a forwarded request holds steady until it is taken;
- no attack pulse follows a quarantined cycle.

Whether a particular request should have passed can only be shown by the bench scenarios. These cover the inclusive region bounds, overlap priority, the unmapped default, size-mask and direction rules, counting up to the threshold and the clear, and a policy swapped during a hold. Each outcome is compared with a reference model of the tables.

// File: rtl/fw_pkg.sv
package fw_pkg;
    localparam int SZW = 3;
    localparam int SZN = 1 << SZW;

    // Policy word: bit0 read allowed, bit1 write allowed, then size mask
    typedef struct packed {
        logic [SZN-1:0] size_mask;
        logic           wr_ok;
        logic           rd_ok;
    } policy_t;

    localparam int POLW = $bits(policy_t);

    typedef enum logic [1:0] {
        CFG_REGION = 2'd0,
        CFG_POLICY = 2'd1,
        CFG_THRESH = 2'd2,
        CFG_CLEAR  = 2'd3
    } cfg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_CHECK,
        ST_FWD,
        ST_WAIT,
        ST_RESP
    } fw_state_e;

    function automatic logic policy_permits(policy_t p, logic wr, logic [SZW-1:0] sz);
        return (wr ? p.wr_ok : p.rd_ok) && p.size_mask[sz];
    endfunction
endpackage

// File: rtl/fw_region_map.sv
module fw_region_map #(
    parameter int AW   = 16,
    parameter int NREG = 8,
    parameter int PIW  = 3,
    parameter int RIW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [RIW-1:0] wr_idx,
    input  logic [AW-1:0]  wr_base,
    input  logic [AW-1:0]  wr_limit,
    input  logic [PIW-1:0] wr_pidx,
    input  logic [AW-1:0]  look_addr,
    output logic           look_hit,
    output logic [PIW-1:0] look_pidx
);
    logic [AW-1:0]  base_q  [NREG];
    logic [AW-1:0]  limit_q [NREG];
    logic [PIW-1:0] pidx_q  [NREG];
    logic [NREG-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                base_q[i]  <= '1;
                limit_q[i] <= '0;
                pidx_q[i]  <= '0;
            end
        end else if (wr_en) begin
            base_q[wr_idx]  <= wr_base;
            limit_q[wr_idx] <= wr_limit;
            pidx_q[wr_idx]  <= wr_pidx;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign match[g] = (look_addr >= base_q[g]) && (look_addr <= limit_q[g]);
    end

    // Lowest-numbered matching region takes priority
    always_comb begin
        look_hit  = 1'b0;
        look_pidx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (match[i]) begin
                look_hit  = 1'b1;
                look_pidx = pidx_q[i];
            end
        end
    end
endmodule

// File: rtl/fw_policy_store.sv
module fw_policy_store
    import fw_pkg::*;
#(
    parameter int NPOL = 8,
    parameter int PIW  = $clog2(NPOL)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [PIW-1:0] wr_idx,
    input  policy_t        wr_pol,
    input  logic [PIW-1:0] rd_idx,
    output policy_t        rd_pol
);
    policy_t pol_q [NPOL];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPOL; i++) pol_q[i] <= '0;
        end else if (wr_en) begin
            pol_q[wr_idx] <= wr_pol;
        end
    end

    assign rd_pol = pol_q[rd_idx];
endmodule

// File: rtl/fw_rule_check.sv
module fw_rule_check
    import fw_pkg::*;
(
    input  logic           hit,
    input  policy_t        pol,
    input  logic           is_write,
    input  logic [SZW-1:0] size,
    input  logic           quar,
    output logic           pass,
    output logic           violation
);
    always_comb begin
        pass      = !quar && hit && policy_permits(pol, is_write, size);
        violation = !quar && !pass;
    end
endmodule

// File: rtl/fw_access_guard.sv
module fw_access_guard
    import fw_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int NREG    = 8,
    parameter int NPOL    = 8,
    parameter int PIW     = $clog2(NPOL),
    parameter int IXW     = $clog2((NREG > NPOL) ? NREG : NPOL),
    parameter int VW      = 4,
    parameter int THR_RST = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [2:0]          req_size,
    input  logic [DW-1:0]       req_wdata,
    output logic                rsp_valid,
    output logic [DW-1:0]       rsp_rdata,
    output logic                rsp_err,
    output logic                fwd_valid,
    input  logic                fwd_ready,
    output logic                fwd_write,
    output logic [AW-1:0]       fwd_addr,
    output logic [2:0]          fwd_size,
    output logic [DW-1:0]       fwd_wdata,
    input  logic                dn_rsp_valid,
    input  logic [DW-1:0]       dn_rdata,
    input  logic                dn_err,
    input  logic                cfg_hold,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_kind,
    input  logic [IXW-1:0]      cfg_index,
    input  logic [2*AW+PIW-1:0] cfg_wdata,
    output logic                attack_evt,
    output logic                quarantined
);
    localparam int RIW = $clog2(NREG);

    typedef struct packed {
        logic           write;
        logic [AW-1:0]  addr;
        logic [SZW-1:0] size;
        logic [DW-1:0]  wdata;
    } txn_t;

    fw_state_e      st_q;
    txn_t           buf_q;
    logic           hit_q;
    logic [PIW-1:0] pidx_q;
    logic [DW-1:0]  rdata_q;
    logic           err_q;
    logic [VW-1:0]  vcnt_q;
    logic [VW-1:0]  thr_q;
    logic           quar_q;
    logic           atk_q;

    cfg_kind_e      kind;
    logic           map_hit;
    logic [PIW-1:0] map_pidx;
    policy_t        cur_pol;
    logic           chk_pass;
    logic           chk_viol;
    logic [VW-1:0]  vcnt_inc;

    assign kind     = cfg_kind_e'(cfg_kind);
    assign vcnt_inc = (vcnt_q == '1) ? vcnt_q : vcnt_q + 1'b1;

    fw_region_map #(.AW(AW), .NREG(NREG), .PIW(PIW)) u_map (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we && kind == CFG_REGION),
        .wr_idx    (cfg_index[RIW-1:0]),
        .wr_base   (cfg_wdata[AW-1:0]),
        .wr_limit  (cfg_wdata[2*AW-1:AW]),
        .wr_pidx   (cfg_wdata[2*AW+PIW-1:2*AW]),
        .look_addr (buf_q.addr),
        .look_hit  (map_hit),
        .look_pidx (map_pidx)
    );

    fw_policy_store #(.NPOL(NPOL), .PIW(PIW)) u_pol (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we && kind == CFG_POLICY),
        .wr_idx (cfg_index[PIW-1:0]),
        .wr_pol (policy_t'(cfg_wdata[POLW-1:0])),
        .rd_idx (pidx_q),
        .rd_pol (cur_pol)
    );

    fw_rule_check u_chk (
        .hit       (hit_q),
        .pol       (cur_pol),
        .is_write  (buf_q.write),
        .size      (buf_q.size),
        .quar      (quar_q),
        .pass      (chk_pass),
        .violation (chk_viol)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            buf_q   <= '0;
            hit_q   <= 1'b0;
            pidx_q  <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            vcnt_q  <= '0;
            thr_q   <= VW'(THR_RST);
            quar_q  <= 1'b0;
            atk_q   <= 1'b0;
        end else begin
            atk_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (req_valid && req_ready) begin
                    buf_q <= '{write: req_write, addr: req_addr, size: req_size, wdata: req_wdata};
                    st_q  <= ST_LOOKUP;
                end
                ST_LOOKUP: if (!cfg_hold) begin
                    hit_q  <= map_hit;
                    pidx_q <= map_pidx;
                    st_q   <= ST_CHECK;
                end
                ST_CHECK: if (!cfg_hold) begin
                    if (chk_pass) begin
                        st_q <= ST_FWD;
                    end else begin
                        err_q   <= 1'b1;
                        rdata_q <= '0;
                        st_q    <= ST_RESP;
                        if (chk_viol) begin
                            atk_q  <= 1'b1;
                            vcnt_q <= vcnt_inc;
                            if (vcnt_inc >= thr_q) quar_q <= 1'b1;
                        end
                    end
                end
                ST_FWD: if (fwd_ready) st_q <= ST_WAIT;
                ST_WAIT: if (dn_rsp_valid) begin
                    err_q   <= dn_err;
                    rdata_q <= dn_err ? '0 : dn_rdata;
                    st_q    <= ST_RESP;
                end
                ST_RESP: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
            if (cfg_we && kind == CFG_THRESH) thr_q <= cfg_wdata[VW-1:0];
            if (cfg_we && kind == CFG_CLEAR) begin
                quar_q <= 1'b0;
                vcnt_q <= '0;
            end
        end
    end

    assign req_ready   = (st_q == ST_IDLE) && !cfg_hold;
    assign rsp_valid   = (st_q == ST_RESP);
    assign rsp_rdata   = rdata_q;
    assign rsp_err     = err_q;
    assign fwd_valid   = (st_q == ST_FWD);
    assign fwd_write   = buf_q.write;
    assign fwd_addr    = buf_q.addr;
    assign fwd_size    = buf_q.size;
    assign fwd_wdata   = buf_q.wdata;
    assign attack_evt  = atk_q;
    assign quarantined = quar_q;
endmodule

// File: rtl/fw_guard_sva.sv
module fw_guard_sva #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          cfg_hold,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic [DW-1:0] rsp_rdata,
    input logic          fwd_valid,
    input logic          fwd_ready,
    input logic [AW-1:0] fwd_addr,
    input logic          attack_evt,
    input logic          quarantined,
    input logic          cfg_we,
    input logic [1:0]    cfg_kind
);
    AST_QUAR_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        quarantined |-> !fwd_valid); // R8
    AST_QUAR_STICKY: assert property (@(posedge clk) disable iff (rst)
        quarantined && !(cfg_we && cfg_kind == 2'd3) |=> quarantined); // R8
    AST_NO_ATTACK_IN_QUAR: assert property (@(posedge clk) disable iff (rst)
        quarantined && !(cfg_we && cfg_kind == 2'd3) |=> !attack_evt); // R8
    AST_HOLD_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        cfg_hold |-> !req_ready); // R9
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_err |-> rsp_rdata == '0); // R5
    AST_ATTACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        attack_evt |=> !attack_evt); // R6
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R10
    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (rst)
        fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_addr)); // R4
endmodule

bind fw_access_guard fw_guard_sva #(.AW(AW), .DW(DW)) u_sva (.*);

// File: tb/test_fw_access_guard.sv
module test_fw_access_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 2 * AW + 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_size = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          fwd_valid, fwd_write;
    logic          fwd_ready = 1'b1;
    logic [AW-1:0] fwd_addr;
    logic [2:0]    fwd_size;
    logic [DW-1:0] fwd_wdata;
    logic          dn_rsp_valid = 1'b0, dn_err = 1'b0;
    logic [DW-1:0] dn_rdata = '0;
    logic          cfg_hold = 1'b0, cfg_we = 1'b0;
    logic [1:0]    cfg_kind = '0;
    logic [2:0]    cfg_index = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          attack_evt, quarantined;

    fw_access_guard i_fw_access_guard (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    int fwd_cnt = 0, atk_cnt = 0;
    logic          lf_write;
    logic [AW-1:0] lf_addr;
    logic [2:0]    lf_size;
    logic [DW-1:0] lf_wdata;

    // Reference tables
    logic [AW-1:0] m_base [8];
    logic [AW-1:0] m_lim  [8];
    logic [2:0]    m_pidx [8];
    logic [9:0]    m_pol  [8];
    int            m_cnt, m_thr;
    logic          m_quar;

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] dn_model(logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    function automatic logic ref_permit(logic wr, logic [AW-1:0] a, logic [2:0] sz);
        for (int i = 0; i < 8; i++)
            if (a >= m_base[i] && a <= m_lim[i])
                return (wr ? m_pol[m_pidx[i]][1] : m_pol[m_pidx[i]][0]) && m_pol[m_pidx[i]][2 + sz];
        return 1'b0;
    endfunction

    // System-side responder
    initial forever begin
        @(negedge clk);
        dn_rsp_valid = 1'b0;
        if (fwd_valid) begin
            fwd_cnt++;
            lf_write = fwd_write; lf_addr = fwd_addr; lf_size = fwd_size; lf_wdata = fwd_wdata;
            @(negedge clk);
            dn_rsp_valid = 1'b1;
            dn_rdata = dn_model(lf_addr);
            dn_err = 1'b0;
        end
    end

    initial forever begin
        @(negedge clk);
        if (attack_evt) atk_cnt++;
    end

    task automatic cfg(input logic [1:0] k, input logic [2:0] idx, input logic [CW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_index = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (k)
            2'd0: begin m_base[idx] = d[AW-1:0]; m_lim[idx] = d[2*AW-1:AW]; m_pidx[idx] = d[2*AW+2:2*AW]; end
            2'd1: m_pol[idx] = d[9:0];
            2'd2: m_thr = int'(d[3:0]);
            default: begin m_quar = 1'b0; m_cnt = 0; end
        endcase
    endtask

    task automatic set_region(input int i, input logic [AW-1:0] b, input logic [AW-1:0] l, input logic [2:0] p);
        cfg(2'd0, 3'(i), {p, l, b});
    endtask

    task automatic set_policy(input int i, input logic rd, input logic wr, input logic [7:0] mask);
        cfg(2'd1, 3'(i), CW'({mask, wr, rd}));
    endtask

    task automatic txn(input logic wr, input logic [AW-1:0] a, input logic [2:0] sz, input logic [DW-1:0] wd, input string tag);
        logic exp_pass, exp_atk;
        int f0, a0, w;
        exp_pass = !m_quar && ref_permit(wr, a, sz);
        exp_atk  = !m_quar && !exp_pass;
        if (exp_atk) begin
            if (m_cnt < 15) m_cnt++;
            if (m_cnt >= m_thr) m_quar = 1'b1;
        end
        f0 = fwd_cnt; a0 = atk_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!rsp_valid && w < 30) begin @(negedge clk); w++; end
        check(rsp_valid, {tag, " R10 response"}, 64'(rsp_valid), 1);
        check(rsp_err == !exp_pass, {tag, " R4/R5 err"}, 64'(rsp_err), 64'(!exp_pass));
        check(rsp_rdata == (exp_pass ? dn_model(a) : '0), {tag, " R5 rdata"}, 64'(rsp_rdata), 64'(exp_pass ? dn_model(a) : '0));
        @(negedge clk);
        check(rsp_valid == 1'b0, {tag, " R10 single pulse"}, 64'(rsp_valid), 0);
        check(fwd_cnt - f0 == (exp_pass ? 1 : 0), {tag, " R4 forward count"}, 64'(fwd_cnt - f0), 64'(exp_pass));
        if (exp_pass)
            check(lf_addr == a && lf_write == wr && lf_size == sz && lf_wdata == wd,
                  {tag, " R4 forwarded fields"}, 64'(lf_addr), 64'(a));
        check(atk_cnt - a0 == (exp_atk ? 1 : 0), {tag, " R6 attack"}, 64'(atk_cnt - a0), 64'(exp_atk));
        check(quarantined == m_quar, {tag, " R7/R8 quarantine"}, 64'(quarantined), 64'(m_quar));
    endtask

    initial begin
        logic done = 1'b0;
        fork
            begin
                #(CLK_PERIOD * 150000);
                if (!done) begin
                    n_cmp++; n_bad++;
                    $display("FAIL watchdog expired actual=hung expected=finished");
                    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                    $finish;
                end
            end
        join_none
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) begin m_base[i] = '1; m_lim[i] = '0; m_pidx[i] = '0; m_pol[i] = '0; end
        m_cnt = 0; m_thr = 3; m_quar = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 1);
        check(!rsp_valid && !fwd_valid && !attack_evt && !quarantined, "R1 idle outputs", 64'({rsp_valid, fwd_valid, attack_evt, quarantined}), 0);

        // Default deny with empty tables
        txn(1'b0, 16'h0000, 3'd0, '0, "R1 empty table");
        txn(1'b1, 16'h1234, 3'd2, 32'hDEAD_BEEF, "R2 unmapped");
        cfg(2'd3, 3'd0, '0);

        set_policy(0, 1'b1, 1'b0, 8'h07);
        set_policy(1, 1'b1, 1'b1, 8'hFF);
        set_policy(2, 1'b0, 1'b1, 8'h04);
        set_policy(3, 1'b0, 1'b1, 8'hFF);
        set_region(0, 16'h0000, 16'h0FFF, 3'd0);
        set_region(1, 16'h1000, 16'h1FFF, 3'd1);
        set_region(2, 16'h1800, 16'h27FF, 3'd2);
        set_region(3, 16'h4000, 16'h4000, 3'd3);
        cfg(2'd2, 3'd0, CW'(15));

        txn(1'b0, 16'h0FFF, 3'd2, '0, "R2 upper bound");
        txn(1'b0, 16'h0000, 3'd0, '0, "R2 lower bound");
        txn(1'b1, 16'h1000, 3'd5, 32'h0102_0304, "R3 write permitted");
        txn(1'b0, 16'h0FFF, 3'd3, '0, "R3 size mask");
        txn(1'b1, 16'h0010, 3'd0, 32'h5, "R3 no write right");
        txn(1'b0, 16'h1800, 3'd0, '0, "R2 overlap priority");
        txn(1'b1, 16'h2000, 3'd2, 32'hCAFE_0001, "R2 second region");
        txn(1'b1, 16'h2000, 3'd1, 32'h1, "R3 size denied");
        txn(1'b1, 16'h4000, 3'd7, 32'h77, "R2 single address");
        txn(1'b1, 16'h4001, 3'd7, 32'h77, "R2 past limit");
        txn(1'b0, 16'h3000, 3'd0, '0, "R2 gap");

        // Quarantine
        cfg(2'd3, 3'd0, '0);
        cfg(2'd2, 3'd0, CW'(2));
        txn(1'b1, 16'h0020, 3'd0, 32'h9, "R7 first violation");
        check(quarantined == 1'b0, "R7 below threshold", 64'(quarantined), 0);
        txn(1'b0, 16'h3000, 3'd0, '0, "R7 second violation");
        check(quarantined == 1'b1, "R7 threshold reached", 64'(quarantined), 1);
        txn(1'b0, 16'h0100, 3'd1, '0, "R8 legal while quarantined");
        repeat (5) @(negedge clk);
        check(quarantined == 1'b1, "R8 sticky", 64'(quarantined), 1);
        cfg(2'd3, 3'd0, '0);
        check(quarantined == 1'b0, "R8 cleared", 64'(quarantined), 0);
        txn(1'b0, 16'h0100, 3'd1, '0, "R8 legal after clear");
        txn(1'b0, 16'h3000, 3'd0, '0, "R8 counter reset");

        // Policy swap under hold
        cfg(2'd3, 3'd0, '0);
        cfg(2'd2, 3'd0, CW'(15));
        @(negedge clk);
        cfg_hold = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1004; req_size = 3'd2; req_wdata = 32'hABCD;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(req_ready == 1'b0 && !fwd_valid && !rsp_valid, "R9 hold blocks", 64'(req_ready), 0);
        end
        set_policy(1, 1'b1, 1'b0, 8'hFF);
        cfg_hold = 1'b0;
        req_valid = 1'b0;
        txn(1'b1, 16'h1004, 3'd2, 32'hABCD, "R9 new policy applies");
        set_policy(1, 1'b1, 1'b1, 8'hFF);

        // Hold raised after acceptance
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0040; req_size = 3'd0;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_hold = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(!fwd_valid && !rsp_valid, "R9 pending not decided", 64'({fwd_valid, rsp_valid}), 0);
        end
        set_policy(0, 1'b0, 1'b0, 8'h00);
        cfg_hold = 1'b0;
        repeat (4) @(negedge clk);
        check(atk_cnt > 0 && quarantined == 1'b0, "R9 swapped policy used", 64'(quarantined), 0);
        cfg(2'd3, 3'd0, '0);
        set_policy(0, 1'b1, 1'b0, 8'h07);
        repeat (3) @(negedge clk);

        // Random traffic
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] a;
            a = AW'($urandom_range(0, 16'h4FFF));
            if (n % 5 == 0) a = 16'h4000;
            txn(1'($urandom), a, 3'($urandom), $urandom, "R3 random");
            if (m_quar) cfg(2'd3, 3'd0, '0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule